// File: doc/BRIEF.md
# Self-Checking GF(2^8) Inverter

This block finds the multiplicative inverse of an 8-bit element of GF(2^8), the nonlinear core of the AES substitution step. The field uses the reduction polynomial x^8 + x^4 + x^3 + x + 1, and the element zero maps to zero. The block does not duplicate the inverter to check it. Instead, a small check unit multiplies the input by the produced inverse in the field and keeps only the R least significant coefficient bits of that product. These bits form the signature. The signature must equal a constant chosen by the input: the value 1 for a nonzero input and 0 for a zero input. Any other value raises the error flag.

Two injection inputs let a bench or a fault campaign XOR an error pattern onto the inverse before it reaches the check unit and the output. A second pattern can be XORed onto the signature. An error pair (eB on the inverse, eR on the signature) escapes detection exactly when the low R bits of input times eB equal eR. For a nonzero input this happens for a fraction 2^-R of patterns.

Data enters and leaves through valid/ready handshakes. With the output register on (the default), a result is held stable while `out_ready` is low. In that state the input is refused with `in_ready` low. `in_ready` is high whenever the register is empty or is being drained in the same cycle. With the register off, the path is purely combinational and the ready signal passes straight through.

Top module: `gf_inv_selfcheck`

## Requirements
- R1: For every nonzero input x with no injection, the field product of x and `out_inv` under polynomial 0x11B is 0x01.
- R2: Input 0x00 with a zero `inj_inv` gives `out_inv` = 0x00.
- R3: `out_sig` equals the low R bits of x times (true inverse XOR `inj_inv`), XORed with `inj_sig`. With R = 2 and no injection, it is binary 01 for nonzero x and 00 for zero x.
- R4: With no injection, `out_err` stays low for all 256 inputs.
- R5: With injection, `out_err` is low exactly when the low R bits of x times `inj_inv` equal `inj_sig`, and is high otherwise.
- R6: For input 0x00, `out_err` equals (`inj_sig` != 0), whatever `inj_inv` holds.
- R7: With the output register on, a result takes one cycle from the accepting edge to the outputs. While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_inv`, `out_sig` and `out_err` hold.
- R8: During reset `out_valid` and `out_err` are low.
- R9: With the output register off, `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and the results appear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Block can take the input this cycle |
| in_data | input | 8 | Field element to invert |
| inj_inv | input | 8 | Error pattern XORed onto the inverse |
| inj_sig | input | R | Error pattern XORed onto the signature |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_inv | output | 8 | Inverse (after injection) |
| out_sig | output | R | Partial-product signature |
| out_err | output | 1 | Signature differs from the expected constant |

## Verification
The hardest case to reach from the ports is an injected error that escapes the check. Random patterns hit this only about one time in four. Half of the injected vectors therefore get a signature error computed in the bench as exactly the low bits of x times the inverse error. This drives the block into escapes on purpose, and the flag is checked to stay low there. The zero input, where no inverse error is visible at all, gets its own targeted set of patterns.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;

  // Multiply a field element by x, reducing with the low byte of the polynomial
  function automatic logic [7:0] gf_xtime(input logic [7:0] a, input logic [7:0] poly);
    return {a[6:0], 1'b0} ^ (a[7] ? poly : 8'h00);
  endfunction

  // Full field multiplication (shift-and-add)
  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b,
                                        input logic [7:0] poly);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh, poly);
    end
    return acc;
  endfunction

  // Carry-less 8x8 product before reduction
  function automatic logic [14:0] clmul8(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] c;
    c = '0;
    for (int i = 0; i < 8; i++)
      if (b[i]) c = c ^ (15'(a) << i);
    return c;
  endfunction

  // Mask of the raw product terms x^k that land on reduced coefficient j
  function automatic logic [14:0] col_mask(input int j, input logic [7:0] poly);
    logic [14:0] m;
    logic [7:0]  p;
    m = '0;
    p = 8'h01;
    for (int k = 0; k < 15; k++) begin
      m[k] = p[j];
      p    = gf_xtime(p, poly);
    end
    return m;
  endfunction

endpackage

// File: rtl/gfinv_core.sv
module gfinv_core
  import gfinv_pkg::*;
#(
  parameter logic [7:0] POLY = 8'h1B
) (
  input  logic [7:0] x,
  output logic [7:0] y
);
  // x^254 = product of x^2, x^4, ..., x^128; zero maps to zero on its own
  logic [7:0] sq;
  logic [7:0] acc;

  always_comb begin
    sq  = x;
    acc = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gf_mul(sq, sq, POLY);
      acc = gf_mul(acc, sq, POLY);
    end
    y = acc;
  end
endmodule

// File: rtl/gfinv_sig.sv
module gfinv_sig
  import gfinv_pkg::*;
#(
  parameter int         R    = 2,
  parameter logic [7:0] POLY = 8'h1B
) (
  input  logic [7:0]   a,
  input  logic [7:0]   b,
  output logic [R-1:0] sig
);
  logic [14:0] raw;
  assign raw = clmul8(a, b);

  // Only the low R reduced coefficients are built
  for (genvar j = 0; j < R; j++) begin : g_bit
    localparam logic [14:0] MASK = col_mask(j, POLY);
    assign sig[j] = ^(raw & MASK);
  end
endmodule

// File: rtl/gfinv_cmp.sv
module gfinv_cmp #(
  parameter int R = 2
) (
  input  logic [7:0]   x,
  input  logic [R-1:0] sig,
  output logic         err
);
  localparam logic [R-1:0] UNIT = R'(1);
  logic [R-1:0] expect_c;

  assign expect_c = (x != 8'h00) ? UNIT : '0;
  assign err      = (sig != expect_c);
endmodule

// File: rtl/gf_inv_selfcheck.sv
module gf_inv_selfcheck #(
  parameter int         R       = 2,
  parameter bit         REG_OUT = 1'b1,
  parameter logic [7:0] POLY    = 8'h1B
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [7:0]   in_data,
  input  logic [7:0]   inj_inv,
  input  logic [R-1:0] inj_sig,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [7:0]   out_inv,
  output logic [R-1:0] out_sig,
  output logic         out_err
);
  logic [7:0]   inv_raw;
  logic [7:0]   inv_hit;
  logic [R-1:0] sig_raw;
  logic [R-1:0] sig_hit;
  logic         err_c;

  gfinv_core #(.POLY(POLY)) u_core (
    .x (in_data),
    .y (inv_raw)
  );

  assign inv_hit = inv_raw ^ inj_inv;

  gfinv_sig #(.R(R), .POLY(POLY)) u_sig (
    .a   (in_data),
    .b   (inv_hit),
    .sig (sig_raw)
  );

  assign sig_hit = sig_raw ^ inj_sig;

  gfinv_cmp #(.R(R)) u_cmp (
    .x   (in_data),
    .sig (sig_hit),
    .err (err_c)
  );

  if (REG_OUT) begin : g_reg
    logic         v_q;
    logic [7:0]   inv_q;
    logic [R-1:0] sig_q;
    logic         err_q;
    logic         take;

    assign in_ready = !v_q || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q   <= 1'b0;
        inv_q <= 8'h00;
        sig_q <= '0;
        err_q <= 1'b0;
      end else if (take) begin
        v_q   <= 1'b1;
        inv_q <= inv_hit;
        sig_q <= sig_hit;
        err_q <= err_c;
      end else if (out_ready) begin
        v_q   <= 1'b0;
      end
    end

    assign out_valid = v_q;
    assign out_inv   = inv_q;
    assign out_sig   = sig_q;
    assign out_err   = err_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_inv   = inv_hit;
    assign out_sig   = sig_hit;
    assign out_err   = err_c;
  end
endmodule

// File: rtl/gfinv_chk.sv
module gfinv_chk #(
  parameter int R       = 2,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [7:0]   in_data,
  input logic [7:0]   inj_inv,
  input logic [R-1:0] inj_sig,
  input logic         out_valid,
  input logic         out_ready,
  input logic [7:0]   out_inv,
  input logic [R-1:0] out_sig,
  input logic         out_err
);
  localparam logic [R-1:0] SIG_ONE = R'(1);
  logic take;
  logic clean;
  assign take  = in_valid && in_ready;
  assign clean = (inj_inv == 8'h00) && (inj_sig == '0);

  if (REG_OUT) begin : g_reg
    // R1
    nonzero_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && in_data != 8'h00 && clean |=> out_valid && out_sig == SIG_ONE && !out_err);
    // R2
    zero_maps_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && in_data == 8'h00 && inj_inv == 8'h00 |=> out_inv == 8'h00);
    // R6
    zero_sig_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take && in_data == 8'h00 && inj_sig != '0 |=> out_err);
    // R7
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_inv) && $stable(out_sig) && $stable(out_err));
    // R8
    always_ff @(posedge clk) begin
      if (!rst_n) reset_idle_chk: assert (!out_valid && !out_err);
    end
  end else begin : g_comb
    // R9
    comb_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_data != 8'h00 && clean |-> out_valid && out_sig == SIG_ONE && !out_err);
    // R6
    comb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_data == 8'h00 && inj_sig != '0 |-> out_err);
    // R9
    comb_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |-> in_ready);
  end
endmodule

bind gf_inv_selfcheck gfinv_chk #(.R(R), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .inj_inv   (inj_inv),
  .inj_sig   (inj_sig),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_inv   (out_inv),
  .out_sig   (out_sig),
  .out_err   (out_err)
);

// File: tb/sim_gf_inv_selfcheck.sv
`timescale 1ns/1ps
module sim_gf_inv_selfcheck;
  localparam int RB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic [7:0]    inj_inv = 8'h00;
  logic [RB-1:0] inj_sig = '0;
  logic          out_ready = 1'b1;

  logic          in_ready, out_valid, out_err;
  logic [7:0]    out_inv;
  logic [RB-1:0] out_sig;
  logic          c_in_ready, c_out_valid, c_out_err;
  logic [7:0]    c_out_inv;
  logic [RB-1:0] c_out_sig;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gf_inv_selfcheck #(.R(RB), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .inj_inv(inj_inv), .inj_sig(inj_sig),
    .out_valid(out_valid), .out_ready(out_ready), .out_inv(out_inv),
    .out_sig(out_sig), .out_err(out_err)
  );

  gf_inv_selfcheck #(.R(RB), .REG_OUT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_data(in_data), .inj_inv(inj_inv), .inj_sig(inj_sig),
    .out_valid(c_out_valid), .out_ready(1'b1), .out_inv(c_out_inv),
    .out_sig(c_out_sig), .out_err(c_out_err)
  );

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] aa;
    logic [7:0] bb;
    logic [7:0] r;
    aa = {1'b0, a};
    bb = b;
    r  = 8'h00;
    while (bb != 8'h00) begin
      if (bb[0]) r = r ^ aa[7:0];
      aa = aa << 1;
      if (aa[8]) aa = aa ^ 9'h11B;
      bb = bb >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] ref_inv(input logic [7:0] x);
    if (x == 8'h00) return 8'h00;
    for (int y = 1; y < 256; y++)
      if (ref_mul(x, 8'(y)) == 8'h01) return 8'(y);
    return 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] x, input logic [7:0] ei, input logic [RB-1:0] es);
    logic [7:0]    inv_e;
    logic [7:0]    prod;
    logic [RB-1:0] sig_e;
    logic          err_e;
    string         etag;
    inv_e = ref_inv(x) ^ ei;
    prod  = ref_mul(x, inv_e);
    sig_e = prod[RB-1:0] ^ es;
    err_e = (sig_e != ((x != 8'h00) ? RB'(1) : RB'(0)));
    if (ei == 8'h00 && es == '0) etag = "R4";
    else if (x == 8'h00)         etag = "R6";
    else                          etag = "R5";
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = x;
    inj_inv  = ei;
    inj_sig  = es;
    #1;
    // R9: combinational variant answers in the same cycle
    check(c_out_valid && c_in_ready && c_out_inv == inv_e && c_out_sig == sig_e
          && c_out_err == err_e, "R9", {c_out_inv, 2'(c_out_sig), c_out_err},
          {inv_e, 2'(sig_e), err_e});
    @(negedge clk);
    // R7: registered result one cycle after acceptance
    check(out_valid, "R7", out_valid, 1);
    check(out_inv == inv_e, (x == 8'h00) ? "R2" : "R1", out_inv, inv_e);
    check(out_sig == sig_e, "R3", out_sig, sig_e);
    check(out_err == err_e, etag, out_err, err_e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8
    check(!out_valid && !out_err, "R8", {out_valid, out_err}, 0);
    rst_n = 1'b1;

    // R1 R2 R3 R4: all 256 inputs without faults
    for (int v = 0; v < 256; v++) drive(8'(v), 8'h00, '0);

    // R5: random pairs; odd iterations are forced escapes
    for (int k = 0; k < 3000; k++) begin
      logic [7:0]    xv, ev, pm;
      logic [RB-1:0] sv;
      xv = 8'($urandom);
      ev = 8'($urandom);
      pm = ref_mul(xv, ev);
      sv = (k % 2 == 1) ? pm[RB-1:0] : RB'($urandom);
      drive(xv, ev, sv);
    end

    // R6: zero input, inverse error invisible
    for (int k = 0; k < 24; k++) drive(8'h00, 8'($urandom), RB'(k));

    // R7: stall behaviour
    @(negedge clk);
    in_valid  = 1'b0;
    inj_inv   = 8'h00;
    inj_sig   = '0;
    out_ready = 1'b1;
    @(negedge clk);
    check(!out_valid, "R7", out_valid, 0);
    in_valid  = 1'b1;
    in_data   = 8'h53;
    out_ready = 1'b0;
    @(negedge clk);
    check(out_valid && out_inv == 8'hCA, "R7", out_inv, 8'hCA);
    check(!in_ready, "R7", in_ready, 0);
    in_data = 8'h02;
    @(negedge clk);
    check(out_valid && out_inv == 8'hCA && out_sig == RB'(1) && !out_err, "R7", out_inv, 8'hCA);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid && out_inv == 8'h8D, "R7", out_inv, 8'h8D);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule